// File: doc/BRIEF.md
# Gradient Orientation Histogram with Vectoring CORDIC

This block builds the orientation histogram for the window of samples around one keypoint. Each sample is a signed horizontal difference, a signed vertical difference and an unsigned weight. A pipelined shift-add CORDIC in vectoring mode turns each difference pair into a magnitude and a full-circle angle. The angle picks one of 36 bins, each 10 degrees wide. The magnitude is multiplied by the weight and added into that bin.

A start pulse clears all bins before a window. The sample marked last closes the window. A fixed number of cycles later the block pulses `done_o` and presents the dominant bin and its value. These stay stable until the next window completes. A combinational read port returns any bin's running total at any time. The differences and the weights are produced upstream. Peak refinement across neighbouring bins happens downstream.

Top module: `grad_orient_hist`

## Requirements
- R1: After reset, every bin reads 0, `done_o` is low, and `peak_bin_o` and `peak_val_o` are 0.
- R2: Each accepted sample adds `wt_i * m` to exactly one bin. `m` is within 3 of 1.64676 * sqrt(dx^2 + dy^2). The CORDIC gain is not removed.
- R3: The bin index is floor(a/10), where a = atan2(dy, dx) in degrees in [0, 360), measured counter-clockwise from the positive dx axis. All four quadrants are covered, including negative dx.
- R4: Angles just below 360 degrees fall in bin 35, and angles just above 0 degrees fall in bin 0. Bins 34 and 1 are left untouched by such samples.
- R5: A cycle with `start_i` high sets all 36 bins to 0. Bins then accumulate across all following samples until the next start.
- R6: While `valid_i` is low, `dx_i`, `dy_i`, `wt_i` and `last_i` have no effect on any bin or on `done_o`.
- R7: `done_o` is high for exactly one cycle. That cycle comes 15 clock edges (ITER+3) after the edge that accepts the sample with `last_i` high.
- R8: When `done_o` is high, `peak_bin_o` is the bin with the largest value and `peak_val_o` is that value. Both hold until the next `done_o`, even across a start.
- R9: When several bins share the largest value, the lowest bin index is reported.
- R10: A bin does not overflow. This holds for 256 samples of maximum magnitude at weight 255.
- R11: `rd_val_o` shows bin `rd_bin_i` combinationally for indices 0..35. Indices 36..63 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears all bins |
| valid_i | input | 1 | Sample valid |
| last_i | input | 1 | Marks the final sample of the window |
| dx_i | input | 9 | Signed horizontal difference |
| dy_i | input | 9 | Signed vertical difference |
| wt_i | input | 8 | Unsigned sample weight |
| rd_bin_i | input | 6 | Bin index for readout |
| rd_val_o | output | 27 | Value of the addressed bin |
| done_o | output | 1 | One-cycle pulse when the window has been accumulated |
| peak_bin_o | output | 6 | Index of the dominant bin |
| peak_val_o | output | 27 | Value of the dominant bin |

## Verification
A wrong rotation direction or a wrong arctangent constant in one CORDIC stage moves energy into a neighbouring bin. This shows on the read port as soon as the window's `done_o` arrives. Samples placed a few degrees from the 0/360 seam and in every quadrant expose pre-rotation and wrap faults. Comparing the peak against the read port on a deliberate tie exposes a peak scan that favours the higher index. A truncated accumulator shows up on the full-scale window as a bin total far below the expected range. A miscounted pipeline register moves the `done_o` pulse off the 15-edge mark.

// File: rtl/goh_pkg.sv
package goh_pkg;
  localparam int ANG_W = 16;  // full turn = 2**ANG_W

  // arctan(2^-idx) in units of 1/65536 turn
  function automatic logic [ANG_W-1:0] atan_step(input int idx);
    logic [ANG_W-1:0] r;
    case (idx)
      0:  r = 16'd8192;
      1:  r = 16'd4836;
      2:  r = 16'd2555;
      3:  r = 16'd1297;
      4:  r = 16'd651;
      5:  r = 16'd326;
      6:  r = 16'd163;
      7:  r = 16'd81;
      8:  r = 16'd41;
      9:  r = 16'd20;
      10: r = 16'd10;
      11: r = 16'd5;
      12: r = 16'd3;
      13: r = 16'd1;
      14: r = 16'd1;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/goh_cordic.sv
module goh_cordic #(
  parameter int DW   = 9,
  parameter int FB   = 4,
  parameter int ITER = 12,
  parameter int SBW  = 9,
  localparam int XW  = DW + FB + 2,
  localparam int MW  = DW + 2,
  localparam int ZW  = goh_pkg::ANG_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] dx_i,
  input  logic signed [DW-1:0] dy_i,
  input  logic [SBW-1:0]       sb_i,
  output logic                 vld_o,
  output logic [MW-1:0]        mag_o,
  output logic [ZW-1:0]        ang_o,
  output logic [SBW-1:0]       sb_o
);
  logic signed [XW-1:0] x_q [ITER+1];
  logic signed [XW-1:0] y_q [ITER+1];
  logic [ZW-1:0]        z_q [ITER+1];
  logic [SBW-1:0]       sb_q [ITER+1];
  logic [ITER:0]        vld_q;
  logic signed [XW-1:0] dx_s, dy_s;

  assign dx_s = XW'(dx_i) <<< FB;
  assign dy_s = XW'(dy_i) <<< FB;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= ITER; i++) begin
        x_q[i]  <= '0;
        y_q[i]  <= '0;
        z_q[i]  <= '0;
        sb_q[i] <= '0;
      end
      vld_q <= '0;
    end else begin
      vld_q   <= {vld_q[ITER-1:0], vld_i};
      sb_q[0] <= sb_i;
      // fold left half-plane onto right half-plane
      if (dx_s < 0) begin
        x_q[0] <= -dx_s;
        y_q[0] <= -dy_s;
        z_q[0] <= {1'b1, {(ZW-1){1'b0}}};
      end else begin
        x_q[0] <= dx_s;
        y_q[0] <= dy_s;
        z_q[0] <= '0;
      end
      for (int i = 0; i < ITER; i++) begin
        sb_q[i+1] <= sb_q[i];
        if (!y_q[i][XW-1]) begin
          x_q[i+1] <= x_q[i] + (y_q[i] >>> i);
          y_q[i+1] <= y_q[i] - (x_q[i] >>> i);
          z_q[i+1] <= z_q[i] + goh_pkg::atan_step(i);
        end else begin
          x_q[i+1] <= x_q[i] - (y_q[i] >>> i);
          y_q[i+1] <= y_q[i] + (x_q[i] >>> i);
          z_q[i+1] <= z_q[i] - goh_pkg::atan_step(i);
        end
      end
    end
  end

  assign vld_o = vld_q[ITER];
  assign mag_o = MW'(x_q[ITER] >>> FB);
  assign ang_o = z_q[ITER];
  assign sb_o  = sb_q[ITER];
endmodule

// File: rtl/goh_binner.sv
module goh_binner #(
  parameter int MW    = 11,
  parameter int WW    = 8,
  parameter int NBINS = 36,
  localparam int BW   = $clog2(NBINS),
  localparam int ZW   = goh_pkg::ANG_W,
  localparam int PW   = MW + WW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic          last_i,
  input  logic [MW-1:0] mag_i,
  input  logic [ZW-1:0] ang_i,
  input  logic [WW-1:0] wt_i,
  output logic          vld_o,
  output logic          last_o,
  output logic [BW-1:0] bin_o,
  output logic [PW-1:0] prod_o
);
  logic [BW-1:0] bin_d;

  // ang spans one turn, so scaling by NBINS and dropping ZW bits gives the bin
  assign bin_d = BW'((32'(ang_i) * 32'(NBINS)) >> ZW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      last_o <= 1'b0;
      bin_o  <= '0;
      prod_o <= '0;
    end else begin
      vld_o  <= vld_i;
      last_o <= vld_i & last_i;
      bin_o  <= bin_d;
      prod_o <= PW'(mag_i) * PW'(wt_i);
    end
  end
endmodule

// File: rtl/goh_peak.sv
module goh_peak #(
  parameter int NBINS = 36,
  parameter int AW    = 27,
  localparam int BW   = $clog2(NBINS)
) (
  input  logic [NBINS-1:0][AW-1:0] acc_i,
  output logic [BW-1:0]            bin_o,
  output logic [AW-1:0]            val_o
);
  // strict compare keeps the earliest index on ties
  always_comb begin
    bin_o = '0;
    val_o = acc_i[0];
    for (int j = 1; j < NBINS; j++) begin
      if (acc_i[j] > val_o) begin
        val_o = acc_i[j];
        bin_o = BW'(j);
      end
    end
  end
endmodule

// File: rtl/grad_orient_hist.sv
module grad_orient_hist #(
  parameter int DW    = 9,
  parameter int WW    = 8,
  parameter int FB    = 4,
  parameter int ITER  = 12,
  parameter int NBINS = 36,
  parameter int WIN   = 256,
  localparam int MW   = DW + 2,
  localparam int PW   = MW + WW,
  localparam int AW   = PW + $clog2(WIN),
  localparam int BW   = $clog2(NBINS),
  localparam int ZW   = goh_pkg::ANG_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 valid_i,
  input  logic                 last_i,
  input  logic signed [DW-1:0] dx_i,
  input  logic signed [DW-1:0] dy_i,
  input  logic [WW-1:0]        wt_i,
  input  logic [BW-1:0]        rd_bin_i,
  output logic [AW-1:0]        rd_val_o,
  output logic                 done_o,
  output logic [BW-1:0]        peak_bin_o,
  output logic [AW-1:0]        peak_val_o
);
  logic                      c_vld;
  logic [MW-1:0]             c_mag;
  logic [ZW-1:0]             c_ang;
  logic [WW:0]               c_sb;
  logic                      b_vld, b_last;
  logic [BW-1:0]             b_bin;
  logic [PW-1:0]             b_prod;
  logic [NBINS-1:0][AW-1:0]  acc_q;
  logic                      fin_q;
  logic [BW-1:0]             best_bin;
  logic [AW-1:0]             best_val;

  goh_cordic #(.DW(DW), .FB(FB), .ITER(ITER), .SBW(WW+1)) u_cordic (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (valid_i),
    .dx_i  (dx_i),
    .dy_i  (dy_i),
    .sb_i  ({last_i, wt_i}),
    .vld_o (c_vld),
    .mag_o (c_mag),
    .ang_o (c_ang),
    .sb_o  (c_sb)
  );

  goh_binner #(.MW(MW), .WW(WW), .NBINS(NBINS)) u_binner (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (c_vld),
    .last_i(c_sb[WW]),
    .mag_i (c_mag),
    .ang_i (c_ang),
    .wt_i  (c_sb[WW-1:0]),
    .vld_o (b_vld),
    .last_o(b_last),
    .bin_o (b_bin),
    .prod_o(b_prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= b_vld & b_last;
      if (start_i) begin
        acc_q <= '0;
      end else if (b_vld) begin
        for (int j = 0; j < NBINS; j++) begin
          if (b_bin == BW'(j)) acc_q[j] <= acc_q[j] + AW'(b_prod);
        end
      end
    end
  end

  goh_peak #(.NBINS(NBINS), .AW(AW)) u_peak (
    .acc_i(acc_q),
    .bin_o(best_bin),
    .val_o(best_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      peak_bin_o <= '0;
      peak_val_o <= '0;
    end else begin
      done_o <= fin_q;
      if (fin_q) begin
        peak_bin_o <= best_bin;
        peak_val_o <= best_val;
      end
    end
  end

  always_comb begin
    rd_val_o = '0;
    for (int j = 0; j < NBINS; j++) begin
      if (rd_bin_i == BW'(j)) rd_val_o = acc_q[j];
    end
  end
endmodule

// File: rtl/goh_chk.sv
module goh_chk #(
  parameter int NBINS = 36,
  parameter int AW    = 27,
  parameter int BW    = 6
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic                     done_o,
  input logic [BW-1:0]            peak_bin_o,
  input logic [AW-1:0]            peak_val_o,
  input logic [BW-1:0]            rd_bin_i,
  input logic [AW-1:0]            rd_val_o,
  input logic [NBINS-1:0][AW-1:0] acc_i
);
  logic [NBINS-1:0][AW-1:0] acc_d;
  logic above, hit, lower_tie;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_d <= '0;
    else         acc_d <= acc_i;
  end

  always_comb begin
    above     = 1'b0;
    hit       = 1'b0;
    lower_tie = 1'b0;
    for (int j = 0; j < NBINS; j++) begin
      if (acc_d[j] > peak_val_o) above = 1'b1;
      if (peak_bin_o == BW'(j) && acc_d[j] == peak_val_o) hit = 1'b1;
      if (BW'(j) < peak_bin_o && acc_d[j] == peak_val_o) lower_tie = 1'b1;
    end
  end

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (acc_i == '0));

  assert_peak_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (hit && !above));

  assert_tie_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !lower_tie);

  assert_rd_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_bin_i >= BW'(NBINS)) |-> (rd_val_o == '0));

  for (genvar j = 0; j < NBINS; j++) begin : g_mono
    assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> (acc_i[j] >= $past(acc_i[j])));
  end
endmodule

bind grad_orient_hist goh_chk #(.NBINS(NBINS), .AW(AW), .BW(BW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .done_o    (done_o),
  .peak_bin_o(peak_bin_o),
  .peak_val_o(peak_val_o),
  .rd_bin_i  (rd_bin_i),
  .rd_val_o  (rd_val_o),
  .acc_i     (acc_q)
);

// File: tb/grad_orient_hist_tb.sv
module grad_orient_hist_tb;
  localparam int  DW = 9, WW = 8, NBINS = 36, AW = 27, BW = 6;
  localparam int  LAT = 16;  // negedges after the push until done is seen (15 edges)
  localparam real GAIN = 1.646760;
  localparam real PI = 3.14159265358979;
  localparam real TOL = 3.0;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst_ni = 1'b0, start_i = 1'b0, valid_i = 1'b0, last_i = 1'b0;
  logic signed [DW-1:0] dx_i = '0, dy_i = '0;
  logic [WW-1:0]        wt_i = '0;
  logic [BW-1:0]        rd_bin_i = '0;
  logic [AW-1:0]        rd_val_o, peak_val_o;
  logic [BW-1:0]        peak_bin_o;
  logic                 done_o;
  int total = 0, bad = 0;

  grad_orient_hist u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .valid_i(valid_i), .last_i(last_i),
    .dx_i(dx_i), .dy_i(dy_i), .wt_i(wt_i), .rd_bin_i(rd_bin_i), .rd_val_o(rd_val_o),
    .done_o(done_o), .peak_bin_o(peak_bin_o), .peak_val_o(peak_val_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input longint act, input real lo, input real hi, input string req);
    chk(real'(act) >= lo && real'(act) <= hi, req, act, longint'((lo + hi) / 2.0));
  endtask

  function automatic real mag_of(input int dx, input int dy);
    return GAIN * $sqrt(real'(dx * dx + dy * dy));
  endfunction

  function automatic int bin_of(input int dx, input int dy);
    real d;
    d = $atan2(real'(dy), real'(dx)) * 180.0 / PI;
    if (d < 0.0) d = d + 360.0;
    return $rtoi(d / 10.0) % NBINS;
  endfunction

  task automatic pulse_start();
    @(negedge clk); valid_i = 1'b0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic push(input int dx, input int dy, input int wt, input bit last);
    @(negedge clk);
    valid_i = 1'b1; dx_i = DW'(dx); dy_i = DW'(dy); wt_i = WW'(wt); last_i = last;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    for (int c = 1; c <= 60 && k == 0; c++) begin
      @(negedge clk);
      if (c == 1) begin valid_i = 1'b0; last_i = 1'b0; end
      if (done_o) k = c;
    end
  endtask

  task automatic rd(input int b, output longint v);
    @(negedge clk); rd_bin_i = BW'(b); #1; v = longint'(rd_val_o);
  endtask

  task automatic count_nonzero(output int n);
    longint v;
    n = 0;
    for (int b = 0; b < NBINS; b++) begin rd(b, v); if (v != 0) n++; end
  endtask

  task automatic t_reset();
    int n;
    chk(done_o == 1'b0, "R1 done low", done_o, 0);
    chk(peak_bin_o == '0, "R1 peak bin", peak_bin_o, 0);
    chk(peak_val_o == '0, "R1 peak value", peak_val_o, 0);
    count_nonzero(n);
    chk(n == 0, "R1 bins zero", n, 0);
  endtask

  task automatic t_single();
    int k, n; longint v; real m;
    pulse_start();
    push(100, 40, 200, 1'b1);
    wait_done(k);
    chk(k == LAT, "R7 done latency", k, LAT);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
    chk(int'(peak_bin_o) == bin_of(100, 40), "R3 bin of first quadrant sample", peak_bin_o, bin_of(100, 40));
    m = mag_of(100, 40);
    chk_rng(longint'(peak_val_o), (m - TOL) * 200.0, (m + TOL) * 200.0, "R2 weighted magnitude");
    rd(2, v);
    chk(v == longint'(peak_val_o), "R8 peak equals bin readout", v, peak_val_o);
    count_nonzero(n);
    chk(n == 1, "R2 single bin touched", n, 1);
  endtask

  task automatic t_quadrants();
    int dxs[5] = '{-100, -30, 60, -5, 70};
    int dys[5] = '{10, -100, -100, 100, 75};
    int k; longint v; real m;
    pulse_start();
    for (int i = 0; i < 5; i++) push(dxs[i], dys[i], 3, i == 4);
    wait_done(k);
    for (int i = 0; i < 5; i++) begin
      m = mag_of(dxs[i], dys[i]);
      rd(bin_of(dxs[i], dys[i]), v);
      chk_rng(v, (m - TOL) * 3.0, (m + TOL) * 3.0, "R3 quadrant bin");
    end
  endtask

  task automatic t_wrap();
    int k; longint v; real m;
    pulse_start();
    push(100, -3, 4, 1'b0);
    push(100, 3, 4, 1'b1);
    wait_done(k);
    m = mag_of(100, 3);
    rd(35, v); chk_rng(v, (m - TOL) * 4.0, (m + TOL) * 4.0, "R4 just below 360 in bin 35");
    rd(0, v);  chk_rng(v, (m - TOL) * 4.0, (m + TOL) * 4.0, "R4 just above 0 in bin 0");
    rd(34, v); chk(v == 0, "R4 bin 34 untouched", v, 0);
    rd(1, v);  chk(v == 0, "R4 bin 1 untouched", v, 0);
  endtask

  task automatic t_clear();
    int n; logic [BW-1:0] pb; logic [AW-1:0] pv;
    pb = peak_bin_o; pv = peak_val_o;
    pulse_start();
    count_nonzero(n);
    chk(n == 0, "R5 start clears bins", n, 0);
    chk(peak_bin_o == pb && peak_val_o == pv, "R8 peak held across start", peak_val_o, pv);
  endtask

  task automatic t_ignore();
    int n; bit seen;
    pulse_start();
    seen = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      valid_i = 1'b0; dx_i = DW'(50 + c); dy_i = DW'(-40); wt_i = 8'hFF; last_i = 1'b1;
      if (done_o) seen = 1'b1;
    end
    @(negedge clk); last_i = 1'b0;
    chk(!seen, "R6 no done without valid", seen, 0);
    count_nonzero(n);
    chk(n == 0, "R6 bins unchanged without valid", n, 0);
  endtask

  task automatic t_accum();
    int k; longint v; real m1, m2;
    pulse_start();
    for (int i = 0; i < 3; i++) push(-60, 85, 10, 1'b0);
    push(60, 100, 20, 1'b1);
    wait_done(k);
    m1 = mag_of(-60, 85); m2 = mag_of(60, 100);
    chk(int'(peak_bin_o) == 12, "R8 dominant bin", peak_bin_o, 12);
    chk_rng(longint'(peak_val_o), (m1 - TOL) * 30.0, (m1 + TOL) * 30.0, "R5 accumulated value");
    rd(5, v); chk_rng(v, (m2 - TOL) * 20.0, (m2 + TOL) * 20.0, "R2 second bin");
  endtask

  task automatic t_tie();
    int k; longint v;
    for (int ord = 0; ord < 2; ord++) begin
      pulse_start();
      if (ord == 0) begin push(100, 20, 50, 1'b0); push(-100, -20, 50, 1'b1); end
      else          begin push(-100, -20, 50, 1'b0); push(100, 20, 50, 1'b1); end
      wait_done(k);
      chk(int'(peak_bin_o) == 1, "R9 tie reports lower bin", peak_bin_o, 1);
      rd(19, v);
      chk(v == longint'(peak_val_o), "R9 tied values equal", v, peak_val_o);
    end
  endtask

  task automatic t_full();
    int k; longint v; real m;
    pulse_start();
    for (int i = 0; i < 256; i++) push(-255, -255, 255, i == 255);
    wait_done(k);
    chk(k == LAT, "R7 latency after long window", k, LAT);
    m = mag_of(-255, -255);
    rd(22, v);
    chk_rng(v, (m - TOL) * 255.0 * 256.0, (m + TOL) * 255.0 * 256.0, "R10 full scale no overflow");
    chk(int'(peak_bin_o) == 22, "R10 full scale peak bin", peak_bin_o, 22);
  endtask

  task automatic t_rd_range();
    longint v;
    rd(36, v); chk(v == 0, "R11 index 36 reads zero", v, 0);
    rd(63, v); chk(v == 0, "R11 index 63 reads zero", v, 0);
    rd(22, v); chk(v != 0, "R11 valid index reads bin", v, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_quadrants();
    t_wrap();
    t_clear();
    t_ignore();
    t_accum();
    t_tie();
    t_full();
    t_rd_range();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule